// File: doc/BRIEF.md
# Valid-Bit Command Ring Tracker

This block is the hardware bookkeeping for an eight-slot command ring that software fills and hardware drains. It keeps a 3-bit producer index with a wrap flag above it, a 3-bit consumer index, an 8-bit fill threshold and a small configuration register. From these it derives free space, fill level and a level-sensitive interrupt.

Software can announce new entries in one of three ways, chosen by a 2-bit mode field. It can write the producer index through a direct register. It can write the same index through an alternate shadow address. Or it can write each entry's command byte with a valid bit whose expected polarity follows the wrap flag. In valid-bit mode the tracker watches entry writes and accepts an entry only when it arrives in the slot the producer index points at and carries the expected polarity. The downstream consumer pulses a retire strobe once per entry it has finished. This block stores no entry payload.

Top module: `valid_ring_tracker`

## Requirements
- R1: After reset the producer index, wrap flag, consumer index, threshold and mode bits are zero. Free space reads 7, fill reads 0 and the interrupt is low.
- R2: Fill is the cyclic distance from consumer to producer: producer minus consumer when the consumer is not above the producer, otherwise 8 plus producer minus consumer. Free space is 7 minus fill.
- R3: In mode 0, a write to address 0 loads the producer index from data bits 2:0 and the wrap flag from data bit 3. A write to address 4 is ignored.
- R4: In mode 1, a write to address 4 loads the producer index and wrap flag with the same bit layout. A write to address 0 is ignored.
- R5: In mode 2, an entry write is accepted only when its slot equals the producer index, bit 7 of its command byte equals the wrap flag, and free space is nonzero. An accepted write advances the producer index by one. Producer register writes are ignored in this mode.
- R6: In mode 2, accepting the entry in slot 7 returns the producer index to 0 and inverts the wrap flag. Entries that still carry the old polarity are then refused.
- R7: The retire strobe advances the consumer index by one, modulo 8, when fill is nonzero. It has no effect when the ring is empty.
- R8: Writes to the consumer index address (1) have no effect.
- R9: The configuration register is at address 3. A write replaces bits 4:0, and the mode is bits 1:0. Bits 7:5 keep their reset value of binary 101, so the register reads 0xA0 after reset. Mode 3 ignores every producer update.
- R10: The threshold register at address 2 is 8 bits wide and can be read and written. The interrupt is high exactly while fill is greater than the threshold.
- R11: Reads are combinational. Addresses 0 and 4 return {wrap, index} in bits 3:0. Address 1 returns the consumer index. Addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ent_wr_en | input | 1 | Entry command-byte write strobe |
| ent_slot | input | 3 | Ring slot being written |
| ent_cmd | input | 8 | Command byte; bit 7 is the valid bit |
| retire | input | 1 | Consumer finished one entry |
| free_cnt | output | 3 | Free slots |
| fill_cnt | output | 3 | Occupied slots |
| irq | output | 1 | Fill above threshold |

## Verification
The assertions assume that software never moves the producer index by a register write beyond the current free space. Without that assumption, the fill and free relations have no meaning. The bench meets this assumption by always adding a random step no larger than the free space to the modelled {wrap, index} value. Random and deliberately wrong slots and polarities go to the entry port. Retire pulses land on both empty and non-empty rings. Mode changes include the reserved mode 3, so every producer path is exercised under the other modes as well.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;

  localparam int unsigned RT_ADDR_W = 3;

  localparam logic [RT_ADDR_W-1:0] RA_PROD_DIRECT = 3'd0;
  localparam logic [RT_ADDR_W-1:0] RA_CONS        = 3'd1;
  localparam logic [RT_ADDR_W-1:0] RA_THRESH      = 3'd2;
  localparam logic [RT_ADDR_W-1:0] RA_CONFIG      = 3'd3;
  localparam logic [RT_ADDR_W-1:0] RA_PROD_SHADOW = 3'd4;

  typedef enum logic [1:0] {
    PM_DIRECT = 2'd0,
    PM_SHADOW = 2'd1,
    PM_VALID  = 2'd2,
    PM_HOLD   = 2'd3
  } prod_mode_e;

endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ring_level.sv
module ring_level #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned THR_W = 8
) (
  input  logic [IDX_W-1:0] prod_idx,
  input  logic [IDX_W-1:0] cons_idx,
  input  logic [THR_W-1:0] thresh,
  output logic [IDX_W-1:0] free_cnt,
  output logic [IDX_W-1:0] fill_cnt,
  output logic             ring_full,
  output logic             ring_empty,
  output logic             irq
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0]   DEPTH_V = DEPTH[IDX_W:0];
  localparam logic [IDX_W-1:0] MAX_FREE = DEPTH_V[IDX_W-1:0] - 1'b1;

  logic [IDX_W:0] dist_w;

  // Cyclic distance: consumer slot counted, producer slot not counted.
  always_comb begin
    if (cons_idx <= prod_idx) dist_w = {1'b0, prod_idx} - {1'b0, cons_idx};
    else                      dist_w = DEPTH_V + {1'b0, prod_idx} - {1'b0, cons_idx};
  end

  assign fill_cnt   = dist_w[IDX_W-1:0];
  assign free_cnt   = MAX_FREE - dist_w[IDX_W-1:0];
  assign ring_full  = (dist_w[IDX_W-1:0] == MAX_FREE);
  assign ring_empty = (dist_w[IDX_W-1:0] == '0);
  assign irq        = (THR_W'(dist_w[IDX_W-1:0]) > thresh);
endmodule

// File: rtl/ring_prod_track.sv
module ring_prod_track
  import ring_trk_pkg::*;
#(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned VB_POS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  prod_mode_e           mode,
  input  logic                 reg_wr_en,
  input  logic [RT_ADDR_W-1:0] reg_addr,
  input  logic [IDX_W:0]       idx_wdata,
  input  logic                 ent_wr_en,
  input  logic [IDX_W-1:0]     ent_slot,
  input  logic [CMD_W-1:0]     ent_cmd,
  input  logic                 ring_full,
  output logic [IDX_W-1:0]     prod_idx,
  output logic                 prod_wrap
);
  localparam logic [IDX_W-1:0] LAST_SLOT = '1;

  logic [IDX_W-1:0] prod_q, prod_d;
  logic             wrap_q, wrap_d;
  logic             idx_wr_hit, vb_hit, prod_en;

  always_comb begin
    idx_wr_hit = reg_wr_en &&
                 (((mode == PM_DIRECT) && (reg_addr == RA_PROD_DIRECT)) ||
                  ((mode == PM_SHADOW) && (reg_addr == RA_PROD_SHADOW)));
    vb_hit     = ent_wr_en && (mode == PM_VALID) && (ent_slot == prod_q) &&
                 (ent_cmd[VB_POS] == wrap_q) && !ring_full;
    prod_en    = idx_wr_hit || vb_hit;
    prod_d     = prod_q;
    wrap_d     = wrap_q;
    if (idx_wr_hit) begin
      prod_d = idx_wdata[IDX_W-1:0];
      wrap_d = idx_wdata[IDX_W];
    end else if (vb_hit) begin
      prod_d = prod_q + 1'b1;
      wrap_d = wrap_q ^ (prod_q == LAST_SLOT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      wrap_q <= 1'b0;
    end else if (prod_en) begin
      prod_q <= prod_d;
      wrap_q <= wrap_d;
    end
  end

  assign prod_idx  = prod_q;
  assign prod_wrap = wrap_q;

  AST_VB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_VALID) |=> (prod_q == $past(prod_q) || prod_q == $past(prod_q) + 1'b1)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_VALID && ring_full) |=> $stable(prod_q)); // R5
  AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_VALID && prod_q == LAST_SLOT) |=> ((prod_q == '0) == (wrap_q != $past(wrap_q)))); // R6
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_HOLD) |=> ($stable(prod_q) && $stable(wrap_q))); // R9
endmodule

// File: rtl/ring_cons_track.sv
module ring_cons_track #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             ring_empty,
  output logic [IDX_W-1:0] cons_idx
);
  logic [IDX_W-1:0] cons_q, cons_d;
  logic             cons_en;

  always_comb begin
    cons_en = retire && !ring_empty;
    cons_d  = cons_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cons_q <= '0;
    else if (cons_en) cons_q <= cons_d;
  end

  assign cons_idx = cons_q;

  AST_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && ring_empty) |=> $stable(cons_q)); // R7
  AST_CONS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(cons_q)); // R7
endmodule

// File: rtl/ring_ctl_regs.sv
module ring_ctl_regs
  import ring_trk_pkg::*;
#(
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned THR_W     = 8,
  parameter int unsigned CFG_LOW_W = 5,
  parameter logic [DATA_W-1:0] CFG_RST = 8'hA0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [RT_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [IDX_W-1:0]     prod_idx,
  input  logic                 prod_wrap,
  input  logic [IDX_W-1:0]     cons_idx,
  output logic [THR_W-1:0]     thresh,
  output prod_mode_e           mode,
  output logic [DATA_W-1:0]    reg_rdata
);
  logic [THR_W-1:0]  thr_q, thr_d;
  logic              thr_en, cfg_en;
  logic [DATA_W-1:0] cfg_q, cfg_d;

  always_comb begin
    thr_en = reg_wr_en && (reg_addr == RA_THRESH);
    cfg_en = reg_wr_en && (reg_addr == RA_CONFIG);
    thr_d  = reg_wdata[THR_W-1:0];
    cfg_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_en) thr_q <= thr_d;
  end

  // Low config bits are writable; upper bits stay at their reset value.
  for (genvar b = 0; b < DATA_W; b++) begin : g_cfg
    if (b < CFG_LOW_W) begin : g_wr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q[b] <= CFG_RST[b];
        else if (cfg_en) cfg_q[b] <= cfg_d[b];
      end
    end else begin : g_fixed
      assign cfg_q[b] = CFG_RST[b];
    end
  end

  assign thresh = thr_q;
  assign mode   = prod_mode_e'(cfg_q[1:0]);

  always_comb begin
    unique case (reg_addr)
      RA_PROD_DIRECT,
      RA_PROD_SHADOW: reg_rdata = DATA_W'({prod_wrap, prod_idx});
      RA_CONS:        reg_rdata = DATA_W'(cons_idx);
      RA_THRESH:      reg_rdata = DATA_W'(thr_q);
      RA_CONFIG:      reg_rdata = cfg_q;
      default:        reg_rdata = '0;
    endcase
  end

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_en |=> $stable(thr_q)); // R10
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_q[CFG_LOW_W-1:0] == $past(reg_wdata[CFG_LOW_W-1:0]))); // R9
endmodule

// File: rtl/valid_ring_tracker.sv
module valid_ring_tracker
  import ring_trk_pkg::*;
#(
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned THR_W     = 8,
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned VB_POS    = 7,
  parameter int unsigned CFG_LOW_W = 5,
  parameter logic [DATA_W-1:0] CFG_RST = 8'hA0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [RT_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 ent_wr_en,
  input  logic [IDX_W-1:0]     ent_slot,
  input  logic [CMD_W-1:0]     ent_cmd,
  input  logic                 retire,
  output logic [IDX_W-1:0]     free_cnt,
  output logic [IDX_W-1:0]     fill_cnt,
  output logic                 irq
);
  logic             rst_sync_n;
  logic [IDX_W-1:0] prod_idx, cons_idx;
  logic             prod_wrap, ring_full, ring_empty;
  logic [THR_W-1:0] thresh;
  prod_mode_e       mode;

  ring_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ring_ctl_regs #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .THR_W(THR_W),
    .CFG_LOW_W(CFG_LOW_W), .CFG_RST(CFG_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .prod_idx(prod_idx), .prod_wrap(prod_wrap),
    .cons_idx(cons_idx), .thresh(thresh), .mode(mode), .reg_rdata(reg_rdata)
  );

  ring_prod_track #(.IDX_W(IDX_W), .CMD_W(CMD_W), .VB_POS(VB_POS)) u_prod (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .idx_wdata(reg_wdata[IDX_W:0]), .ent_wr_en(ent_wr_en),
    .ent_slot(ent_slot), .ent_cmd(ent_cmd), .ring_full(ring_full),
    .prod_idx(prod_idx), .prod_wrap(prod_wrap)
  );

  ring_cons_track #(.IDX_W(IDX_W)) u_cons (
    .clk(clk), .rst_n(rst_sync_n), .retire(retire), .ring_empty(ring_empty),
    .cons_idx(cons_idx)
  );

  ring_level #(.IDX_W(IDX_W), .THR_W(THR_W)) u_level (
    .prod_idx(prod_idx), .cons_idx(cons_idx), .thresh(thresh),
    .free_cnt(free_cnt), .fill_cnt(fill_cnt), .ring_full(ring_full),
    .ring_empty(ring_empty), .irq(irq)
  );

  AST_CONS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_en && reg_addr == RA_CONS && !retire) |=> $stable(cons_idx)); // R8
  AST_FREE_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (retire && !ent_wr_en && !reg_wr_en && fill_cnt != '0) |=> (free_cnt == $past(free_cnt) + 1'b1)); // R7
endmodule

// File: tb/tb_valid_ring_tracker.sv
`timescale 1ns/1ps
module tb_valid_ring_tracker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en, ent_wr_en, retire;
  logic [2:0] reg_addr, ent_slot;
  logic [7:0] reg_wdata, ent_cmd, reg_rdata;
  logic [2:0] free_cnt, fill_cnt;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [2:0] m_pi, m_ci;
  logic       m_wrap;
  logic [7:0] m_thr;
  logic [4:0] m_cfg;

  always #2.5 clk = ~clk;

  valid_ring_tracker dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_wr_en(ent_wr_en),
    .ent_slot(ent_slot), .ent_cmd(ent_cmd), .retire(retire),
    .free_cnt(free_cnt), .fill_cnt(fill_cnt), .irq(irq)
  );

  function automatic logic [2:0] f_dist(input logic [2:0] first, input logic [2:0] last);
    int d;
    if (first <= last) d = int'(last) - int'(first);
    else               d = 8 + int'(last) - int'(first);
    return d[2:0];
  endfunction

  function automatic logic [2:0] f_fill();
    return f_dist(m_ci, m_pi);
  endfunction

  function automatic logic [2:0] f_free();
    return 3'd7 - f_fill();
  endfunction

  function automatic logic [7:0] f_rdata(input logic [2:0] a);
    case (a)
      3'd0, 3'd4: return {4'd0, m_wrap, m_pi};
      3'd1:       return {5'd0, m_ci};
      3'd2:       return m_thr;
      3'd3:       return {3'b101, m_cfg};
      default:    return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " rdata"}, reg_rdata, f_rdata(reg_addr));
    chk("R2 free", {5'd0, free_cnt}, {5'd0, f_free()});
    chk("R2 fill", {5'd0, fill_cnt}, {5'd0, f_fill()});
    chk("R10 irq", {7'd0, irq}, {7'd0, ({5'd0, f_fill()} > m_thr)});
  endtask

  task automatic step(input logic we, input logic [2:0] ad, input logic [7:0] wd,
                      input logic ew, input logic [2:0] sl, input logic [7:0] cm,
                      input logic rt, input string tag);
    logic [1:0] mode;
    logic [2:0] n_pi, n_ci;
    logic       n_wrap;
    logic [7:0] n_thr;
    logic [4:0] n_cfg;
    reg_wr_en = we; reg_addr = ad; reg_wdata = wd;
    ent_wr_en = ew; ent_slot = sl; ent_cmd = cm; retire = rt;
    mode = m_cfg[1:0];
    n_pi = m_pi; n_wrap = m_wrap; n_ci = m_ci; n_thr = m_thr; n_cfg = m_cfg;
    if (we && ((ad == 3'd0 && mode == 2'd0) || (ad == 3'd4 && mode == 2'd1))) begin
      n_pi = wd[2:0]; n_wrap = wd[3];
    end else if (ew && mode == 2'd2 && sl == m_pi && cm[7] == m_wrap && f_free() != 0) begin
      n_pi = m_pi + 3'd1;
      if (m_pi == 3'd7) n_wrap = ~m_wrap;
    end
    if (rt && f_fill() != 0) n_ci = m_ci + 3'd1;
    if (we && ad == 3'd2) n_thr = wd;
    if (we && ad == 3'd3) n_cfg = wd[4:0];
    @(posedge clk);
    #1;
    m_pi = n_pi; m_wrap = n_wrap; m_ci = n_ci; m_thr = n_thr; m_cfg = n_cfg;
    reg_wr_en = 1'b0; ent_wr_en = 1'b0; retire = 1'b0;
    check_all(tag);
  endtask

  task automatic rd(input logic [2:0] ad, input string tag);
    step(1'b0, ad, 8'd0, 1'b0, 3'd0, 8'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] wd, input string tag);
    step(1'b1, ad, wd, 1'b0, 3'd0, 8'd0, 1'b0, tag);
  endtask

  task automatic ent(input logic [2:0] sl, input logic vb, input string tag);
    step(1'b0, 3'd0, 8'd0, 1'b1, sl, {vb, 7'h15}, 1'b0, tag);
  endtask

  task automatic ret(input string tag);
    step(1'b0, 3'd1, 8'd0, 1'b0, 3'd0, 8'd0, 1'b1, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr_en = 0; ent_wr_en = 0; retire = 0;
    reg_addr = 0; reg_wdata = 0; ent_slot = 0; ent_cmd = 0;
    m_pi = 0; m_ci = 0; m_wrap = 0; m_thr = 0; m_cfg = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 free", {5'd0, free_cnt}, 8'd7);
    chk("R1 fill", {5'd0, fill_cnt}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    rd(3'd0, "R1 prod");
    rd(3'd1, "R1 cons");
    rd(3'd2, "R1 thr");
    rd(3'd3, "R9 cfg reset");
    chk("R9 cfg reset value", reg_rdata, 8'hA0);
    rd(3'd6, "R11 unused addr");

    // valid-bit mode: fill the ring
    wr(3'd3, 8'h02, "R9 mode2");
    for (int s = 0; s < 7; s++) ent(s[2:0], 1'b0, "R5 accept");
    chk("R5 full fill", {5'd0, fill_cnt}, 8'd7);
    chk("R5 full free", {5'd0, free_cnt}, 8'd0);
    ent(3'd7, 1'b0, "R5 full ignored");
    rd(3'd0, "R5 prod after full");
    chk("R5 prod stays 7", reg_rdata, 8'h07);
    ret("R7 retire");
    ret("R7 retire");
    ent(3'd7, 1'b0, "R6 last slot");
    rd(3'd4, "R6 wrap read");
    chk("R6 wrap set", reg_rdata, 8'h08);
    ent(3'd0, 1'b0, "R6 stale polarity");
    chk("R6 stale refused", {5'd0, fill_cnt}, 8'd6);
    ent(3'd0, 1'b1, "R6 new polarity");
    ent(3'd3, 1'b1, "R5 wrong slot");
    wr(3'd0, 8'h05, "R5 reg write ignored");
    wr(3'd4, 8'h05, "R5 shadow write ignored");
    for (int k = 0; k < 8; k++) ret("R7 drain");
    chk("R7 empty", {5'd0, fill_cnt}, 8'd0);
    ret("R7 retire on empty");
    wr(3'd1, 8'h06, "R8 cons write");
    rd(3'd1, "R8 cons read");

    // mode 0 and mode 1
    wr(3'd3, 8'h00, "R9 mode0");
    wr(3'd4, 8'h03, "R3 shadow ignored");
    wr(3'd0, 8'h0D, "R3 direct write");
    rd(3'd0, "R3 readback");
    chk("R3 value", reg_rdata, 8'h0D);
    wr(3'd3, 8'h01, "R9 mode1");
    wr(3'd0, 8'h0E, "R4 direct ignored");
    wr(3'd4, 8'h0F, "R4 shadow write");
    rd(3'd4, "R4 readback");

    // mode 3 and upper config bits
    wr(3'd3, 8'h5F, "R9 mode3 upper kept");
    chk("R9 upper bits", reg_rdata, 8'hBF);
    wr(3'd0, 8'h02, "R9 hold direct");
    wr(3'd4, 8'h02, "R9 hold shadow");
    step(1'b0, 3'd0, 8'd0, 1'b1, m_pi, {m_wrap, 7'h01}, 1'b0, "R9 hold entry");

    // threshold boundary
    wr(3'd3, 8'h00, "R9 mode0 again");
    wr(3'd2, 8'h03, "R10 thr write");
    wr(3'd0, {4'd0, m_wrap, m_ci + 3'd3}, "R10 fill3");
    chk("R10 irq at equal", {7'd0, irq}, 8'd0);
    wr(3'd0, {4'd0, m_wrap, m_ci + 3'd4}, "R10 fill4");
    chk("R10 irq above", {7'd0, irq}, 8'd1);

    // constrained random
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: begin
          logic [2:0] sl;
          logic       vb;
          sl = ($urandom_range(0, 4) == 0) ? 3'($urandom_range(0, 7)) : m_pi;
          vb = ($urandom_range(0, 5) == 0) ? ~m_wrap : m_wrap;
          step(1'b0, 3'($urandom_range(0, 7)), 8'd0, 1'b1, sl, {vb, 7'($urandom)},
               1'($urandom_range(0, 1)), "R5 R6 rand entry");
        end
        3: ret("R7 rand retire");
        4: begin
          logic [3:0] v;
          v = {m_wrap, m_pi} + 4'($urandom_range(0, int'(f_free())));
          step(1'b1, ($urandom_range(0, 1) == 0) ? 3'd0 : 3'd4, {4'($urandom), v},
               1'b0, 3'd0, 8'd0, 1'($urandom_range(0, 1)), "R3 R4 rand prod");
        end
        5: wr(3'd1, 8'($urandom), "R8 rand cons");
        6: wr(3'd2, 8'($urandom_range(0, 8)), "R10 rand thr");
        7: begin
          logic [1:0] md;
          md = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
          wr(3'd3, {6'($urandom), md}, "R9 rand cfg");
        end
        default: rd(3'($urandom_range(0, 7)), "R11 rand read");
      endcase
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule